// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block picks which of eight interrupt lines should be raised to the processor. It takes a request vector and a mask vector, both held in registers elsewhere, and ranks the unmasked requests. The ranking is measured from a rotating base line: the base line has the highest priority, and priority falls by one for each step around the ring after it. A winner is raised only if it outranks every interrupt that is already in service, so a running handler can be interrupted only by a more urgent line.

The block owns two pieces of state: the in-service vector and the rotation base. An acknowledge moves the current winner into service, or, in automatic end-of-interrupt mode, can rotate the base past it instead. Command strobes retire in-service lines, either the most urgent one or a named one, and can move the base. A nesting option on the primary instance leaves the cascade line out of the in-service level, so a secondary controller can raise further requests through that line while it is in service.

Top module: `nest_prio_resolver`

## Requirements
- R1: After reset, `in_service` is 0, `prio_base` is 0 and `irq_pending` is 0 while no request is present.
- R2: The candidates are `req_vec & ~mask_vec`. Line L has priority (L - `prio_base`) mod 8, and 0 is the most urgent. `win_line` is the most urgent candidate when `irq_pending` is 1, and reads 0 when it is 0. With no candidates, `irq_pending` is 0.
- R3: `irq_pending` is 1 only when the best candidate priority is numerically lower than the best priority among the in-service bits, all in-service bits being clear counting as priority 8.
- R4: With `nest_en` high on a primary instance (`IS_PRIMARY`=1), in-service bit `CASCADE_LINE` (default 2) is left out of the in-service level of R3. It still counts for the retire-most-urgent command of R7.
- R5: `ack` with `irq_pending` high and `auto_eoi_en` low sets in-service bit `win_line` on the next clock. `ack` with `irq_pending` low changes no state.
- R6: `ack` with `irq_pending` high and `auto_eoi_en` high leaves `in_service` unchanged. If `rot_auto_en` is also high, `prio_base` becomes (`win_line`+1) mod 8.
- R7: `cmd_op` encoding, taken when `cmd_valid` is high: 0 none; 1 retire the most urgent in-service bit, ranked from `prio_base`; 2 the same and set `prio_base` to (that line+1) mod 8; 6 and 7 none. Codes 1 and 2 do nothing when `in_service` is 0.
- R8: `cmd_op` 3 clears in-service bit `cmd_arg`; 4 sets `prio_base` to (`cmd_arg`+1) mod 8; 5 does both.
- R9: An acknowledge and a command in the same cycle both take effect. An in-service bit set by the acknowledge survives a clear of the same bit. A base change made by the command overrides one made by the acknowledge.
- R10: `irq_pending` and `win_line` follow the current inputs and state in the same cycle. `in_service` and `prio_base` change only on the clock edge after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vec | input | 8 | Captured request vector |
| mask_vec | input | 8 | Mask vector, 1 blocks a line |
| nest_en | input | 1 | Leave the cascade line out of the in-service level |
| auto_eoi_en | input | 1 | Acknowledge does not enter service |
| rot_auto_en | input | 1 | Rotate the base on an automatic end of interrupt |
| ack | input | 1 | Processor acknowledge of the current winner |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (R7, R8) |
| cmd_arg | input | 3 | Line operand of a command |
| irq_pending | output | 1 | A winner outranks the in-service level |
| win_line | output | 3 | Winning line number |
| in_service | output | 8 | In-service vector |
| prio_base | output | 3 | Current highest-priority line |

## Verification
An acknowledge and an end-of-interrupt command can land in the same cycle. Both also compete for the rotation base. A random sweep drives `ack` and `cmd_valid` together with independent probabilities. Every such cycle is judged against the merge order of R9 in a bench model of the state. Directed cases then clear the very bit being acknowledged, and request a base change from both sources at once, to pin down which side wins.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic [2:0] {
    OP_NONE         = 3'd0,
    OP_EOI_TOP      = 3'd1,
    OP_EOI_TOP_ROT  = 3'd2,
    OP_EOI_LINE     = 3'd3,
    OP_SET_BASE     = 3'd4,
    OP_EOI_LINE_ROT = 3'd5
  } prn_op_e;
endpackage

// File: rtl/prn_search.sv
// Finds the most urgent set bit of a vector, ranked from a rotating base.
// prio == N means the vector is empty.
module prn_search #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] base,
  output logic [LW:0]   prio
);
  logic [N-1:0] rot;

  // rot[p] holds the line whose priority is p
  for (genvar g = 0; g < N; g++) begin : g_rot
    assign rot[g] = vec[LW'(g) + base];
  end

  always_comb begin
    prio = (LW+1)'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) prio = (LW+1)'(i);
    end
  end
endmodule

// File: rtl/prn_state.sv
// In-service vector and rotation base, with acknowledge and command updates.
module prn_state
  import prn_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_fire,
  input  logic [LW-1:0] ack_line,
  input  logic          auto_eoi_en,
  input  logic          rot_auto_en,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_arg,
  input  logic          top_found,
  input  logic [LW-1:0] top_line,
  output logic [N-1:0]  isr_q,
  output logic [LW-1:0] base_q,
  output logic [N-1:0]  ack_set_vec,
  output logic [N-1:0]  cmd_clr_vec,
  output logic          cmd_base_upd
);
  function automatic logic [LW-1:0] after_line(input logic [LW-1:0] l);
    return l + LW'(1);
  endfunction

  logic          ack_base_upd;
  logic [LW-1:0] ack_base;
  logic [LW-1:0] cmd_base;
  prn_op_e       op;

  assign op = prn_op_e'(cmd_op);

  always_comb begin
    ack_set_vec  = '0;
    ack_base_upd = 1'b0;
    ack_base     = base_q;
    if (ack_fire) begin
      if (!auto_eoi_en) begin
        ack_set_vec[ack_line] = 1'b1;
      end else if (rot_auto_en) begin
        ack_base_upd = 1'b1;
        ack_base     = after_line(ack_line);
      end
    end
  end

  always_comb begin
    cmd_clr_vec  = '0;
    cmd_base_upd = 1'b0;
    cmd_base     = base_q;
    if (cmd_valid) begin
      case (op)
        OP_EOI_TOP, OP_EOI_TOP_ROT: begin
          if (top_found) begin
            cmd_clr_vec[top_line] = 1'b1;
            if (op == OP_EOI_TOP_ROT) begin
              cmd_base_upd = 1'b1;
              cmd_base     = after_line(top_line);
            end
          end
        end
        OP_EOI_LINE: cmd_clr_vec[cmd_arg] = 1'b1;
        OP_SET_BASE: begin
          cmd_base_upd = 1'b1;
          cmd_base     = after_line(cmd_arg);
        end
        OP_EOI_LINE_ROT: begin
          cmd_clr_vec[cmd_arg] = 1'b1;
          cmd_base_upd         = 1'b1;
          cmd_base             = after_line(cmd_arg);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q <= (isr_q & ~cmd_clr_vec) | ack_set_vec;
      if (cmd_base_upd)      base_q <= cmd_base;
      else if (ack_base_upd) base_q <= ack_base;
    end
  end
endmodule

// File: rtl/nest_prio_resolver.sv
module nest_prio_resolver #(
  parameter int N            = 8,
  parameter int CASCADE_LINE = 2,
  parameter bit IS_PRIMARY   = 1'b1,
  localparam int LW          = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_vec,
  input  logic [N-1:0]  mask_vec,
  input  logic          nest_en,
  input  logic          auto_eoi_en,
  input  logic          rot_auto_en,
  input  logic          ack,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_arg,
  output logic          irq_pending,
  output logic [LW-1:0] win_line,
  output logic [N-1:0]  in_service,
  output logic [LW-1:0] prio_base
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_LINE;

  function automatic logic [LW-1:0] line_of(input logic [LW:0] p,
                                             input logic [LW-1:0] b);
    return p[LW-1:0] + b;
  endfunction

  logic [N-1:0] cand_vec;
  logic [N-1:0] level_vec;
  logic [LW:0]  cand_prio;
  logic [LW:0]  level_prio;
  logic [LW:0]  top_prio;
  logic         top_found;
  logic [LW-1:0] top_line;
  logic         ack_fire;
  logic [N-1:0] ack_set_vec;
  logic [N-1:0] cmd_clr_vec;
  logic         cmd_base_upd;

  assign cand_vec  = req_vec & ~mask_vec;
  assign level_vec = (IS_PRIMARY && nest_en) ? (in_service & ~CASC_BIT) : in_service;

  prn_search #(.N(N), .LW(LW)) u_cand  (.vec(cand_vec),   .base(prio_base), .prio(cand_prio));
  prn_search #(.N(N), .LW(LW)) u_level (.vec(level_vec),  .base(prio_base), .prio(level_prio));
  prn_search #(.N(N), .LW(LW)) u_top   (.vec(in_service), .base(prio_base), .prio(top_prio));

  assign irq_pending = (cand_prio < level_prio);
  assign win_line    = irq_pending ? line_of(cand_prio, prio_base) : '0;
  assign top_found   = (top_prio != (LW+1)'(N));
  assign top_line    = line_of(top_prio, prio_base);
  assign ack_fire    = ack && irq_pending;

  prn_state #(.N(N), .LW(LW)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_fire    (ack_fire),
    .ack_line    (win_line),
    .auto_eoi_en (auto_eoi_en),
    .rot_auto_en (rot_auto_en),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_arg     (cmd_arg),
    .top_found   (top_found),
    .top_line    (top_line),
    .isr_q       (in_service),
    .base_q      (prio_base),
    .ack_set_vec (ack_set_vec),
    .cmd_clr_vec (cmd_clr_vec),
    .cmd_base_upd(cmd_base_upd)
  );
endmodule

// File: rtl/nest_prio_resolver_chk.sv
module nest_prio_resolver_chk #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_vec,
  input logic [N-1:0]  mask_vec,
  input logic          ack,
  input logic          auto_eoi_en,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [LW-1:0] cmd_arg,
  input logic          irq_pending,
  input logic [LW-1:0] win_line,
  input logic [N-1:0]  in_service,
  input logic [LW-1:0] prio_base,
  input logic [N-1:0]  ack_set_vec,
  input logic [N-1:0]  cmd_clr_vec
);
  // R2
  pend_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (req_vec[win_line] && !mask_vec[win_line]));

  // R2
  no_cand_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vec & ~mask_vec) == '0) |-> !irq_pending);

  // R5
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pending && !auto_eoi_en) |=> in_service[$past(win_line)]);

  // R5
  idle_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !(ack && irq_pending)) |=> ($stable(in_service) && $stable(prio_base)));

  // R7
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_clr_vec) && $onehot0(ack_set_vec));

  // R8
  set_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> (prio_base == LW'($past(cmd_arg) + LW'(1))));
endmodule

bind nest_prio_resolver nest_prio_resolver_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
  .ack(ack), .auto_eoi_en(auto_eoi_en), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_arg(cmd_arg), .irq_pending(irq_pending),
  .win_line(win_line), .in_service(in_service), .prio_base(prio_base),
  .ack_set_vec(ack_set_vec), .cmd_clr_vec(cmd_clr_vec)
);

// File: tb/nest_prio_resolver_bench.sv
module nest_prio_resolver_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_vec = '0, mask_vec = '0;
  logic       nest_en = 1'b0, auto_eoi_en = 1'b0, rot_auto_en = 1'b0;
  logic       ack = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_arg = '0;
  logic       irq_pending;
  logic [2:0] win_line;
  logic [7:0] in_service;
  logic [2:0] prio_base;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_isr = '0;
  logic [2:0] m_base = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_prio_resolver u_nest_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .nest_en(nest_en), .auto_eoi_en(auto_eoi_en), .rot_auto_en(rot_auto_en),
    .ack(ack), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .irq_pending(irq_pending), .win_line(win_line),
    .in_service(in_service), .prio_base(prio_base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rank: first set bit walking the ring from the base; 8 = empty
  function automatic int rank(input logic [7:0] v, input int b);
    for (int p = 0; p < 8; p++) if (v[(b + p) % 8]) return p;
    return 8;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ack = 0; cmd_valid = 0; req_vec = '0; mask_vec = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_isr = '0; m_base = '0;
    #1;
    chk("R1 in_service", 32'(in_service), 0);
    chk("R1 prio_base", 32'(prio_base), 0);
    chk("R1 irq_pending", 32'(irq_pending), 0);
  endtask

  task automatic step(input logic [7:0] rq, input logic [7:0] mk, input logic ne,
                      input logic ae, input logic ra, input logic ak,
                      input logic cv, input logic [2:0] op, input logic [2:0] arg);
    int cp, lp, tp, el;
    logic ep;
    logic [7:0] clr, set;
    logic [2:0] nb;
    @(negedge clk);
    req_vec = rq; mask_vec = mk; nest_en = ne; auto_eoi_en = ae;
    rot_auto_en = ra; ack = ak; cmd_valid = cv; cmd_op = op; cmd_arg = arg;
    #1;
    cp = rank(rq & ~mk, int'(m_base));
    lp = rank(ne ? (m_isr & ~8'h04) : m_isr, int'(m_base));
    ep = (cp < lp);
    el = ep ? (cp + int'(m_base)) % 8 : 0;
    chk("R2 R3 R4 irq_pending", 32'(irq_pending), 32'(ep));
    chk("R2 win_line", 32'(win_line), 32'(el));
    chk("R10 in_service before edge", 32'(in_service), 32'(m_isr));
    clr = '0; set = '0; nb = m_base;
    if (ak && ep) begin
      if (!ae) set[el] = 1'b1;
      else if (ra) nb = 3'((el + 1) % 8);
    end
    if (cv) begin
      case (op)
        3'd1, 3'd2: begin
          tp = rank(m_isr, int'(m_base));
          if (tp < 8) begin
            clr[(tp + int'(m_base)) % 8] = 1'b1;
            if (op == 3'd2) nb = 3'((tp + int'(m_base) + 1) % 8);
          end
        end
        3'd3: clr[arg] = 1'b1;
        3'd4: nb = arg + 3'd1;
        3'd5: begin clr[arg] = 1'b1; nb = arg + 3'd1; end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    m_isr = (m_isr & ~clr) | set;
    m_base = nb;
    chk("R5 R6 R7 R8 R9 in_service", 32'(in_service), 32'(m_isr));
    chk("R6 R7 R8 R9 prio_base", 32'(prio_base), 32'(m_base));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // sweep every request pattern from every base, empty service level
    for (int b = 0; b < 8; b++) begin
      step(8'h00, 8'h00, 0, 0, 0, 0, 1, 3'd4, 3'(b - 1));
      chk("R8 set base sweep", 32'(prio_base), 32'(b));
      for (int r = 0; r < 256; r++) begin
        step(8'(r), 8'h00, 0, 0, 0, 0, 0, 3'd0, 3'd0);
        step(8'(r), 8'hA5, 0, 0, 0, 0, 0, 3'd0, 3'd0);
      end
    end

    // random mix of acks and commands, state tracked by the model
    do_reset();
    for (int i = 0; i < 5000; i++) begin
      logic [31:0] a, c;
      a = rnd(); c = rnd();
      step(a[7:0], a[15:8] & c[15:8], c[16], c[17] & c[18], c[19],
           a[16] | a[17], c[20] & c[21], c[24:22], c[27:25]);
    end

    // R4: nesting mode lets a request through the cascade line in service
    do_reset();
    step(8'h04, 8'h00, 1, 0, 0, 1, 0, 3'd0, 3'd0);
    chk("R5 cascade in service", 32'(in_service), 32'h04);
    step(8'h08, 8'h00, 1, 0, 0, 0, 0, 3'd0, 3'd0);
    chk("R4 nested lower line pending", 32'(irq_pending), 1);
    step(8'h08, 8'h00, 0, 0, 0, 0, 0, 3'd0, 3'd0);
    chk("R4 blocked without nesting", 32'(irq_pending), 0);
    step(8'h04, 8'h00, 1, 0, 0, 0, 0, 3'd0, 3'd0);
    chk("R4 cascade line retriggers", 32'(win_line), 2);
    step(8'h00, 8'h00, 1, 0, 0, 0, 1, 3'd1, 3'd0);
    chk("R4 R7 top retire still sees cascade bit", 32'(in_service), 0);

    // R9: same-cycle acknowledge and command
    do_reset();
    step(8'h01, 8'h00, 0, 0, 0, 1, 1, 3'd3, 3'd0);
    chk("R9 ack survives clear of same bit", 32'(in_service), 32'h01);
    step(8'h00, 8'h00, 0, 0, 0, 0, 1, 3'd1, 3'd0);
    chk("R7 retire most urgent", 32'(in_service), 0);
    step(8'h02, 8'h00, 0, 1, 1, 1, 1, 3'd4, 3'd4);
    chk("R9 command base wins", 32'(prio_base), 5);
    step(8'h02, 8'h00, 0, 1, 1, 1, 0, 3'd0, 3'd0);
    chk("R6 auto rotate base", 32'(prio_base), 2);
    chk("R6 auto eoi no service", 32'(in_service), 0);
    step(8'h00, 8'h00, 0, 0, 0, 1, 0, 3'd0, 3'd0);
    chk("R5 idle ack ignored", 32'(in_service), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule